// File: doc/BRIEF.md
# Transmit Output Port Router

This block sits at the very end of a transmit datapath. It takes six rounded sample paths of 22 bits each (primary I and Q, secondary I and Q, and two extra real paths) and places them on four 16-bit output ports. Port A always carries the primary I path. Ports B, C and D are each steered by their own one-hot select. A select can pick a zero word, the upper 16 bits of a path, the 6 low-order bits of a path (so that a 22-bit word can be split across two ports), or the bitwise inverse of a neighbouring port (so that two ports form a complementary pair).

A single control bit switches every sample-carrying word from two's complement to offset binary by inverting its top bit. All four ports are registered on the same clock edge. A complementary pair therefore changes in the same cycle, and every port has exactly one cycle of latency from its inputs.

Top module: `txo_port_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four ports become zero on that edge.
- R2: One cycle after any edge that is not in reset, `port_a` equals bits 21..6 of `path_ia`, with bit 15 inverted when `offset_bin` is 1.
- R3: `sel_b` = 1 puts bits 21..6 of `path_ib` on `port_b`; `sel_b` = 2 puts bits 21..6 of `path_qa` on it.
- R4: The low-bit codes place bits 5..0 of a path on port bits 15..10 and force port bits 9..0 to zero, with no top-bit inversion. `sel_b` = 4 uses `path_ia`, `sel_d` = 4 uses `path_ib` and `sel_d` = 8 uses `path_qa`.
- R5: `sel_b` = 8 makes `port_b` the bitwise inverse of the word that `port_a` takes on the same edge.
- R6: `sel_c` = 1, 2 and 4 put bits 21..6 of `path_ic`, `path_ib` and `path_qa` on `port_c`.
- R7: `sel_d` = 1 and 2 put bits 21..6 of `path_id` and `path_qb` on `port_d`. `sel_d` = 16 makes `port_d` the bitwise inverse of the word that `port_c` takes on the same edge.
- R8: A select of zero, or any select value that does not have exactly one bit set, drives its port to all zeros, with no top-bit inversion.
- R9: `offset_bin` inverts bit 15 only on words taken from a path's upper bits. Zero words and low-bit words are unaffected. A complement word is the inverse of the neighbour port's final word.
- R10: All four ports update on the same rising edge, one cycle after their inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| path_ia | input | 22 | Primary I sample |
| path_qa | input | 22 | Primary Q sample |
| path_ib | input | 22 | Secondary I sample |
| path_qb | input | 22 | Secondary Q sample |
| path_ic | input | 22 | Third real sample path |
| path_id | input | 22 | Fourth real sample path |
| sel_b | input | 4 | One-hot source select for port B |
| sel_c | input | 3 | One-hot source select for port C |
| sel_d | input | 5 | One-hot source select for port D |
| offset_bin | input | 1 | 1 = invert the top bit of sample words |
| port_a | output | 16 | Registered output port A |
| port_b | output | 16 | Registered output port B |
| port_c | output | 16 | Registered output port C |
| port_d | output | 16 | Registered output port D |

## Verification
Every legal code of every select is driven with `offset_bin` both clear and set, using paths that hold distinct values. A wrong source, a missing top-bit inversion or an inversion on a low-bit word therefore shows up as a mismatch. Illegal codes, both multi-bit and wide values, are driven with non-zero paths, which separates the zeroing behaviour from a simple OR of the candidates. Long random runs mix legal and illegal codes with changing paths on every cycle. The port pairs are checked on every cycle, which exposes a complement taken from a stale value or from the wrong neighbour.

// File: rtl/txo_pkg.sv
package txo_pkg;

    localparam int PATH_W  = 22;
    localparam int PORT_W  = 16;
    localparam int SEL_B_W = 4;
    localparam int SEL_C_W = 3;
    localparam int SEL_D_W = 5;
    localparam int N_PATHS = 6;
    localparam int N_PORTS = 4;

    // Path slot numbering inside the router
    localparam int IDX_IA = 0;
    localparam int IDX_QA = 1;
    localparam int IDX_IB = 2;
    localparam int IDX_QB = 3;
    localparam int IDX_IC = 4;
    localparam int IDX_ID = 5;

    // Port slot numbering inside the output stage
    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_C = 2'd2,
        PORT_D = 2'd3
    } port_id_e;

    // True when exactly one bit of the (zero-extended) select is set
    function automatic logic single_hot(input logic [31:0] s);
        return (s != 32'd0) && ((s & (s - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/txo_path_shaper.sv
module txo_path_shaper #(
    parameter int PATH_W = txo_pkg::PATH_W,
    parameter int PORT_W = txo_pkg::PORT_W
) (
    input  logic [PATH_W-1:0] path_in,
    input  logic              offset_bin,
    output logic [PORT_W-1:0] word_hi,
    output logic [PORT_W-1:0] word_lo
);
    localparam int LOW_W = PATH_W - PORT_W;
    localparam int PAD_W = PORT_W - LOW_W;

    always_comb begin
        word_hi = path_in[PATH_W-1 -: PORT_W];
        word_hi[PORT_W-1] = path_in[PATH_W-1] ^ offset_bin;
        word_lo = {path_in[LOW_W-1:0], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/txo_onehot_mux.sv
module txo_onehot_mux #(
    parameter int N = 4,
    parameter int W = txo_pkg::PORT_W
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] cand,
    output logic [W-1:0]        y
);
    logic legal;

    always_comb begin
        legal = txo_pkg::single_hot(32'(sel));
        y = '0;
        for (int i = 0; i < N; i++) begin
            if (legal && sel[i]) begin
                y = y | cand[i];
            end
        end
    end
endmodule

// File: rtl/txo_out_stage.sv
module txo_out_stage #(
    parameter int N = txo_pkg::N_PORTS,
    parameter int W = txo_pkg::PORT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0][W-1:0] d,
    output logic [N-1:0][W-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else begin
                q[g] <= d[g];
            end
        end
    end
endmodule

// File: rtl/txo_port_router.sv
module txo_port_router
    import txo_pkg::*;
#(
    parameter int P_PATH_W = txo_pkg::PATH_W,
    parameter int P_PORT_W = txo_pkg::PORT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_PATH_W-1:0] path_ia,
    input  logic [P_PATH_W-1:0] path_qa,
    input  logic [P_PATH_W-1:0] path_ib,
    input  logic [P_PATH_W-1:0] path_qb,
    input  logic [P_PATH_W-1:0] path_ic,
    input  logic [P_PATH_W-1:0] path_id,
    input  logic [SEL_B_W-1:0]  sel_b,
    input  logic [SEL_C_W-1:0]  sel_c,
    input  logic [SEL_D_W-1:0]  sel_d,
    input  logic                offset_bin,
    output logic [P_PORT_W-1:0] port_a,
    output logic [P_PORT_W-1:0] port_b,
    output logic [P_PORT_W-1:0] port_c,
    output logic [P_PORT_W-1:0] port_d
);
    logic [N_PATHS-1:0][P_PATH_W-1:0] paths;
    logic [N_PATHS-1:0][P_PORT_W-1:0] hi_w;
    logic [N_PATHS-1:0][P_PORT_W-1:0] lo_w;

    assign paths[IDX_IA] = path_ia;
    assign paths[IDX_QA] = path_qa;
    assign paths[IDX_IB] = path_ib;
    assign paths[IDX_QB] = path_qb;
    assign paths[IDX_IC] = path_ic;
    assign paths[IDX_ID] = path_id;

    for (genvar g = 0; g < N_PATHS; g++) begin : g_shape
        txo_path_shaper #(.PATH_W(P_PATH_W), .PORT_W(P_PORT_W)) shaper_i (
            .path_in    (paths[g]),
            .offset_bin (offset_bin),
            .word_hi    (hi_w[g]),
            .word_lo    (lo_w[g])
        );
    end

    logic [N_PORTS-1:0][P_PORT_W-1:0] nxt;
    logic [N_PORTS-1:0][P_PORT_W-1:0] cur;
    logic [SEL_B_W-1:0][P_PORT_W-1:0] cand_b;
    logic [SEL_C_W-1:0][P_PORT_W-1:0] cand_c;
    logic [SEL_D_W-1:0][P_PORT_W-1:0] cand_d;

    assign nxt[PORT_A] = hi_w[IDX_IA];

    assign cand_b[0] = hi_w[IDX_IB];
    assign cand_b[1] = hi_w[IDX_QA];
    assign cand_b[2] = lo_w[IDX_IA];
    assign cand_b[3] = ~nxt[PORT_A];

    assign cand_c[0] = hi_w[IDX_IC];
    assign cand_c[1] = hi_w[IDX_IB];
    assign cand_c[2] = hi_w[IDX_QA];

    assign cand_d[0] = hi_w[IDX_ID];
    assign cand_d[1] = hi_w[IDX_QB];
    assign cand_d[2] = lo_w[IDX_IB];
    assign cand_d[3] = lo_w[IDX_QA];
    assign cand_d[4] = ~nxt[PORT_C];

    txo_onehot_mux #(.N(SEL_B_W), .W(P_PORT_W)) mux_b_i (
        .sel (sel_b), .cand (cand_b), .y (nxt[PORT_B])
    );
    txo_onehot_mux #(.N(SEL_C_W), .W(P_PORT_W)) mux_c_i (
        .sel (sel_c), .cand (cand_c), .y (nxt[PORT_C])
    );
    txo_onehot_mux #(.N(SEL_D_W), .W(P_PORT_W)) mux_d_i (
        .sel (sel_d), .cand (cand_d), .y (nxt[PORT_D])
    );

    txo_out_stage #(.N(N_PORTS), .W(P_PORT_W)) stage_i (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign port_a = cur[PORT_A];
    assign port_b = cur[PORT_B];
    assign port_c = cur[PORT_C];
    assign port_d = cur[PORT_D];
endmodule

// File: rtl/txo_port_router_chk.sv
module txo_port_router_chk (
    input logic        clk,
    input logic        rst,
    input logic [21:0] path_ia,
    input logic [21:0] path_qa,
    input logic [3:0]  sel_b,
    input logic [2:0]  sel_c,
    input logic [4:0]  sel_d,
    input logic        offset_bin,
    input logic [15:0] port_a,
    input logic [15:0] port_b,
    input logic [15:0] port_c,
    input logic [15:0] port_d
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=>
        (port_a == 16'h0 && port_b == 16'h0 && port_c == 16'h0 && port_d == 16'h0));

    // R2
    port_a_src_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=>
        port_a == {$past(path_ia[21]) ^ $past(offset_bin), $past(path_ia[20:6])});

    // R5
    cmp_b_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 4'd8) |=> (port_b == ~port_a));

    // R7
    cmp_d_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_d == 5'd16) |=> (port_d == ~port_c));

    // R4
    low_b_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 4'd4) |=> (port_b == {$past(path_ia[5:0]), 10'h0}));

    // R4
    low_d_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_d == 5'd8) |=> (port_d == {$past(path_qa[5:0]), 10'h0}));

    // R8
    illegal_b_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel_b) != 1) |=> (port_b == 16'h0));

    // R8
    illegal_c_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel_c) != 1) |=> (port_c == 16'h0));
endmodule

bind txo_port_router txo_port_router_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .path_ia    (path_ia),
    .path_qa    (path_qa),
    .sel_b      (sel_b),
    .sel_c      (sel_c),
    .sel_d      (sel_d),
    .offset_bin (offset_bin),
    .port_a     (port_a),
    .port_b     (port_b),
    .port_c     (port_c),
    .port_d     (port_d)
);

// File: tb/txo_port_router_tb_top.sv
module txo_port_router_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] ia = '0, qa = '0, ib = '0, qb = '0, ic = '0, id = '0;
    logic [3:0]  sb = '0;
    logic [2:0]  sc = '0;
    logic [4:0]  sd = '0;
    logic        ob = 1'b0;
    logic [15:0] pa, pb, pc, pd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    txo_port_router dut_i (
        .clk(clk), .rst(rst),
        .path_ia(ia), .path_qa(qa), .path_ib(ib), .path_qb(qb),
        .path_ic(ic), .path_id(id),
        .sel_b(sb), .sel_c(sc), .sel_d(sd), .offset_bin(ob),
        .port_a(pa), .port_b(pb), .port_c(pc), .port_d(pd)
    );

    function automatic logic [15:0] m_hi(logic [21:0] p, logic inv);
        return {p[21] ^ inv, p[20:6]};
    endfunction
    function automatic logic [15:0] m_lo(logic [21:0] p);
        return {p[5:0], 10'h000};
    endfunction
    function automatic logic [15:0] m_a();
        return m_hi(ia, ob);
    endfunction
    function automatic logic [15:0] m_b();
        case (sb)
            4'd1: return m_hi(ib, ob);
            4'd2: return m_hi(qa, ob);
            4'd4: return m_lo(ia);
            4'd8: return ~m_a();
            default: return 16'h0;
        endcase
    endfunction
    function automatic logic [15:0] m_c();
        case (sc)
            3'd1: return m_hi(ic, ob);
            3'd2: return m_hi(ib, ob);
            3'd4: return m_hi(qa, ob);
            default: return 16'h0;
        endcase
    endfunction
    function automatic logic [15:0] m_d();
        case (sd)
            5'd1:  return m_hi(id, ob);
            5'd2:  return m_hi(qb, ob);
            5'd4:  return m_lo(ib);
            5'd8:  return m_lo(qa);
            5'd16: return ~m_c();
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs are applied after a falling edge, registered on the next rising
    // edge, and compared at the falling edge that follows it.
    task automatic step(string req);
        logic [15:0] ea, eb, ec, ed;
        ea = m_a(); eb = m_b(); ec = m_c(); ed = m_d();
        @(negedge clk);
        chk({req, " R2 port A"}, pa, ea);
        chk({req, " port B"}, pb, eb);
        chk({req, " port C"}, pc, ec);
        chk({req, " port D"}, pd, ed);
    endtask

    task automatic rand_paths();
        ia = 22'($urandom); qa = 22'($urandom); ib = 22'($urandom);
        qb = 22'($urandom); ic = 22'($urandom); id = 22'($urandom);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));

        // R1: reset with busy inputs drives zeros
        ia = 22'h3FFFFF; qa = 22'h2AAAAA; ib = 22'h155555;
        sb = 4'd8; sc = 3'd1; sd = 5'd16; ob = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 port A", pa, 16'h0);
        chk("R1 port B", pb, 16'h0);
        chk("R1 port C", pc, 16'h0);
        chk("R1 port D", pd, 16'h0);
        rst = 1'b0;

        // Distinct path values for the directed codes
        ia = 22'h2D1F3A; qa = 22'h1B7C25; ib = 22'h35A0C9;
        qb = 22'h0F3E16; ic = 22'h2468AC; id = 22'h13579B;
        for (int inv = 0; inv < 2; inv++) begin
            ob = 1'(inv);
            // R3 R6 R7 R9 path selections
            sb = 4'd1; sc = 3'd1; sd = 5'd1;  step("R3 R6 R7 R9 code1");
            sb = 4'd2; sc = 3'd2; sd = 5'd2;  step("R3 R6 R7 R9 code2");
            // R4 low-bit selections, no inversion
            sb = 4'd4; sc = 3'd4; sd = 5'd4;  step("R4 R9 low");
            sd = 5'd8;                        step("R4 R9 low qa");
            // R5 R7 complement pairs
            sb = 4'd8; sc = 3'd1; sd = 5'd16; step("R5 R7 cmp");
            sc = 3'd0;                        step("R7 R8 cmp of zero");
            // R8 zero and illegal codes
            sb = 4'd0; sc = 3'd0; sd = 5'd0;  step("R8 zero");
            sb = 4'd3; sc = 3'd3; sd = 5'd31; step("R8 illegal a");
            sb = 4'd15; sc = 3'd7; sd = 5'd6; step("R8 illegal b");
            sb = 4'd12; sc = 3'd5; sd = 5'd24; step("R8 illegal c");
        end

        // R10: every port updates together under random traffic
        for (int n = 0; n < 3000; n++) begin
            rand_paths();
            ob = 1'($urandom);
            if ($urandom % 4 == 0) begin
                sb = 4'($urandom); sc = 3'($urandom); sd = 5'($urandom);
            end else begin
                sb = 4'(1 << ($urandom % 4));
                sc = 3'(1 << ($urandom % 3));
                sd = 5'(1 << ($urandom % 5));
            end
            step("R10 random");
        end

        // R1: reset again mid-stream
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again A", pa, 16'h0);
        chk("R1 reset again D", pd, 16'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule